// File: doc/BRIEF.md
# Serial PHY Management Master with Local Register Bypass

This block acts as the host side of a two-wire clause-22 management bus. It divides the system clock down to a management clock (MDC) and shifts frames on the bidirectional data line, which it drives or releases through an output enable. A host issues a single request that carries the direction, a PHY address, a register number and the write data. The block raises `busy` while a serial frame is in flight. It pulses `done` for one cycle at the end and holds the read result on `rdata` until the next read completes.

Every serial transaction begins with a run of driven-high synchronisation bits. A read then sends a 16-bit header and releases the line for 19 clocks. A write sends a 32-bit frame and then releases the line for two more clocks. A PHY address above 31 does not produce a serial frame. That request goes to a small local register file that stands in for an integrated transceiver. It finishes one cycle after it is accepted and MDC does not toggle.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are all 0.
- R2: Each serial transaction starts with PRE_LEN (at least 32) MDC periods in which `mdio_out` is 1 and `mdio_oe` is 1.
- R3: A read then drives 16 header bits, MSB first, at consecutive MDC rising edges: 1,1, 0,1, 1,0, the five low PHY address bits, then the five register bits.
- R4: After the read header, `mdio_oe` is 0 for exactly 19 MDC rising edges. The line is sampled at each of those rising edges. `rdata` equals the 19 samples shifted right by one and truncated to 16 bits, so samples 3 to 18 give data bits 15 to 0.
- R5: A write drives a 32-bit frame, MSB first: 0,1, 0,1, the five PHY address bits, the five register bits, 1,0, then the 16 data bits.
- R6: A write ends with exactly two MDC rising edges with `mdio_oe` at 0. `done` follows, after PRE_LEN+34 rising edges in total.
- R7: The MDC period is 2*DIV_HALF system clocks. Elaboration fails if CLK_HZ/(2*DIV_HALF) exceeds 2.5 MHz.
- R8: `mdio_out` and `mdio_oe` change only on the edge where MDC falls or while MDC is low. They never change during a high phase.
- R9: `busy` is 1 from the cycle after a serial request is accepted until the cycle in which `done` pulses, and it is 0 in that cycle. `done` lasts one cycle. A request made while `busy` is 1 is ignored. A request made in the `done` cycle is accepted.
- R10: A request with PHY address above 31 is handled locally. `done` is 1 in the next cycle, `busy` stays 0 and MDC does not toggle. Registers 0, 1, 4, 5 and 6 store written values, and their reset values are 16'h1000, 16'h7809, 16'h01E1, 16'h0000 and 16'h0000.
- R11: A local access to any other register number reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when busy is 0 |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_phy | input | PHY_W | PHY address; a value above 31 selects the local registers |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Serial transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value |

## Verification
The `done` pulse that ends a serial read and the acceptance of the next request can fall in the same cycle. The bench waits for `done` and, in that same cycle, presents a serial write. It then checks that `busy` rises one cycle later and that the full write frame that follows is correct bit by bit. A local request made while a serial frame is in flight covers the opposite case. The bench checks that it produces no `done` and that a later local read shows the target register unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int DATA_W        = 16;
   localparam int REG_W         = 5;
   localparam int RD_HDR_BITS   = 16;
   localparam int WR_FRAME_BITS = 32;
   localparam int RD_REL_BITS   = 19;
   localparam int WR_REL_BITS   = 2;
   localparam int NSLOT         = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_DRV,
      ST_REL
   } eng_state_t;

   // register numbers backed by local storage, slot order
   function automatic logic [REG_W-1:0] slot_addr(input int s);
      case (s)
         0:       return 5'd0;
         1:       return 5'd1;
         2:       return 5'd4;
         3:       return 5'd5;
         default: return 5'd6;
      endcase
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic bit_end
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt;
   logic          at_last;

   assign at_last = (cnt == LAST);
   assign rise    = run && !mdc && at_last;
   assign bit_end = run &&  mdc && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (at_last) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < DIV_HALF);
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic [REG_W-1:0]  phy,
   input  logic [REG_W-1:0]  regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mdio_in,
   input  logic              mdc,
   input  logic              rise,
   input  logic              bit_end,
   output logic              run,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              busy,
   output logic              done,
   output logic              fin,
   output logic              fin_rd,
   output logic [DATA_W-1:0] fin_data
);
   localparam int CMAX = (PRE_LEN > WR_FRAME_BITS) ? PRE_LEN : WR_FRAME_BITS;
   localparam int BCW  = $clog2(CMAX + 1);
   localparam logic [BCW-1:0] PRE_LAST = BCW'(PRE_LEN - 1);
   localparam logic [BCW-1:0] RD_DRV_LAST = BCW'(RD_HDR_BITS - 1);
   localparam logic [BCW-1:0] WR_DRV_LAST = BCW'(WR_FRAME_BITS - 1);
   localparam logic [BCW-1:0] RD_REL_LAST = BCW'(RD_REL_BITS - 1);
   localparam logic [BCW-1:0] WR_REL_LAST = BCW'(WR_REL_BITS - 1);

   eng_state_t                 state;
   logic [BCW-1:0]             cnt;
   logic [WR_FRAME_BITS-1:0]   sh;
   logic [RD_REL_BITS-1:0]     acc;
   logic                       is_wr;
   logic [BCW-1:0]             drv_last;
   logic [BCW-1:0]             rel_last;
   logic [WR_FRAME_BITS-1:0]   load_frame;

   assign drv_last = is_wr ? WR_DRV_LAST : RD_DRV_LAST;
   assign rel_last = is_wr ? WR_REL_LAST : RD_REL_LAST;
   assign run      = (state != ST_IDLE);
   assign busy     = (state != ST_IDLE);
   assign fin      = (state == ST_REL) && bit_end && (cnt == rel_last);
   assign fin_rd   = !is_wr;
   assign fin_data = DATA_W'(acc >> 1);

   always_comb begin
      if (wr)
         load_frame = {2'b01, 2'b01, phy, regad, 2'b10, wdata};
      else
         load_frame = {2'b11, 2'b01, 2'b10, phy, regad, {DATA_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         acc      <= '0;
         is_wr    <= 1'b0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_PRE;
                  cnt      <= '0;
                  is_wr    <= wr;
                  sh       <= load_frame;
                  acc      <= '0;
                  mdio_out <= 1'b1;
                  mdio_oe  <= 1'b1;
               end
            end
            ST_PRE: begin
               if (bit_end) begin
                  if (cnt == PRE_LAST) begin
                     state    <= ST_DRV;
                     cnt      <= '0;
                     mdio_out <= sh[WR_FRAME_BITS-1];
                     sh       <= sh << 1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DRV: begin
               if (bit_end) begin
                  if (cnt == drv_last) begin
                     state    <= ST_REL;
                     cnt      <= '0;
                     mdio_out <= 1'b0;
                     mdio_oe  <= 1'b0;
                  end else begin
                     cnt      <= cnt + 1'b1;
                     mdio_out <= sh[WR_FRAME_BITS-1];
                     sh       <= sh << 1;
                  end
               end
            end
            ST_REL: begin
               if (rise)
                  acc <= {acc[RD_REL_BITS-2:0], mdio_in};
               if (bit_end) begin
                  if (cnt == rel_last) begin
                     state <= ST_IDLE;
                     cnt   <= '0;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r2_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> (mdio_out && mdio_oe));
   a_r8_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));
   a_r4_released_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && state == ST_REL) |-> !mdio_oe);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/mdio_local_regs.sv
module mdio_local_regs
   import mdio_pkg::*;
#(
   parameter logic [DATA_W-1:0] CTRL_RST = 16'h1000,
   parameter logic [DATA_W-1:0] STAT_RST = 16'h7809,
   parameter logic [DATA_W-1:0] ADV_RST  = 16'h01E1,
   parameter logic [DATA_W-1:0] LPA_RST  = 16'h0000,
   parameter logic [DATA_W-1:0] EXP_RST  = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [NSLOT-1:0][DATA_W-1:0] RST =
      {EXP_RST, LPA_RST, ADV_RST, STAT_RST, CTRL_RST};

   logic [DATA_W-1:0] q [NSLOT];
   logic [NSLOT-1:0]  hit;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign hit[s] = (addr == slot_addr(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[s] <= RST[s];
         else if (we && hit[s])
            q[s] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < NSLOT; s++)
         if (hit[s]) rdata = q[s];
   end

   a_r11_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter longint CLK_HZ      = 50_000_000,
   parameter longint MDC_MAX_HZ  = 2_500_000,
   parameter int     DIV_HALF    = 10,
   parameter int     PRE_LEN     = 32,
   parameter bit     LOCAL_EN    = 1'b1,
   parameter int     PHY_W       = 6,
   parameter logic [15:0] CTRL_RST = 16'h1000,
   parameter logic [15:0] STAT_RST = 16'h7809,
   parameter logic [15:0] ADV_RST  = 16'h01E1,
   parameter logic [15:0] LPA_RST  = 16'h0000,
   parameter logic [15:0] EXP_RST  = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [PHY_W-1:0] req_phy,
   input  logic [4:0]       req_reg,
   input  logic [15:0]      req_wdata,
   output logic             busy,
   output logic             done,
   output logic [15:0]      rdata,
   output logic             mdc,
   output logic             mdio_out,
   output logic             mdio_oe,
   input  logic             mdio_in
);
   if (PRE_LEN < 32) begin : g_chk_pre
      $error("preamble shorter than 32 bits");
   end
   if (DIV_HALF < 1) begin : g_chk_div
      $error("divider must be at least 1");
   end
   if (CLK_HZ > MDC_MAX_HZ * 2 * longint'(DIV_HALF)) begin : g_chk_rate
      $error("management clock above 2.5 MHz");
   end
   if (PHY_W < 5) begin : g_chk_phy
      $error("PHY address narrower than 5 bits");
   end

   logic              run, rise, bit_end;
   logic              loc_sel, acc_loc, acc_ser;
   logic              eng_done, loc_done;
   logic              fin, fin_rd;
   logic [DATA_W-1:0] fin_data, loc_q;
   logic [DATA_W-1:0] rdata_r;

   if (LOCAL_EN && PHY_W > 5) begin : g_local
      assign loc_sel = (req_phy > PHY_W'(31));
      mdio_local_regs #(
         .CTRL_RST (CTRL_RST),
         .STAT_RST (STAT_RST),
         .ADV_RST  (ADV_RST),
         .LPA_RST  (LPA_RST),
         .EXP_RST  (EXP_RST)
      ) u_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (acc_loc && req_write),
         .addr  (req_reg),
         .wdata (req_wdata),
         .rdata (loc_q)
      );
   end else begin : g_nolocal
      assign loc_sel = 1'b0;
      assign loc_q   = '0;
   end

   assign acc_loc = req_valid && !busy && loc_sel;
   assign acc_ser = req_valid && !busy && !loc_sel;

   mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .mdc     (mdc),
      .rise    (rise),
      .bit_end (bit_end)
   );

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc_ser),
      .wr       (req_write),
      .phy      (req_phy[4:0]),
      .regad    (req_reg),
      .wdata    (req_wdata),
      .mdio_in  (mdio_in),
      .mdc      (mdc),
      .rise     (rise),
      .bit_end  (bit_end),
      .run      (run),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe),
      .busy     (busy),
      .done     (eng_done),
      .fin      (fin),
      .fin_rd   (fin_rd),
      .fin_data (fin_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_done <= 1'b0;
         rdata_r  <= '0;
      end else begin
         loc_done <= acc_loc;
         if (fin && fin_rd)
            rdata_r <= fin_data;
         else if (acc_loc && !req_write)
            rdata_r <= loc_q;
      end
   end

   assign done  = eng_done | loc_done;
   assign rdata = rdata_r;

   a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_done && loc_done));
   a_r10_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      loc_done |-> (!mdc && !mdio_oe));
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin) |=> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
   localparam int TCLK = 10;
   localparam int PRE  = 32;
   localparam int DIVH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [5:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, mdc, mdio_out, mdio_oe;
   logic        mdio_in = 1'b1;
   logic [15:0] rdata;

   int errors = 0, checks = 0;
   int edge_cnt = 0;
   int hi_viol = 0;
   logic out_bits [0:127];
   logic oe_bits  [0:127];
   time  rise_t [0:1];
   logic [18:0] rd_pat = '1;

   always #(TCLK/2) clk = ~clk;

   mdio_master #(
      .CLK_HZ(10_000_000), .DIV_HALF(DIVH), .PRE_LEN(PRE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   // PHY-side capture of every driven bit
   always @(posedge mdc) begin
      if (edge_cnt < 128) begin
         out_bits[edge_cnt] = mdio_out;
         oe_bits[edge_cnt]  = mdio_oe;
      end
      if (edge_cnt < 2) rise_t[edge_cnt] = $time;
      edge_cnt = edge_cnt + 1;
   end

   // PHY-side response for released bits
   always @(negedge mdc) begin
      if (edge_cnt >= PRE + 16 && edge_cnt < PRE + 35)
         mdio_in = rd_pat[18 - (edge_cnt - PRE - 16)];
      else
         mdio_in = 1'b1;
   end

   // data must not move during a high phase
   logic p_mdc = 1'b0, p_out = 1'b0, p_oe = 1'b0;
   always @(negedge clk) begin
      if (mdc && p_mdc && (mdio_out !== p_out || mdio_oe !== p_oe))
         hi_viol = hi_viol + 1;
      p_mdc = mdc; p_out = mdio_out; p_oe = mdio_oe;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // call at a negedge; returns at the following negedge
   task automatic issue(input logic w, input logic [5:0] p, input logic [4:0] r,
                        input logic [15:0] d);
      req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (done !== 1'b1 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk("R9 done seen", {31'd0, done}, 32'd1);
   endtask

   task automatic check_read_frame(input logic [4:0] p, input logic [4:0] r);
      logic [15:0] hdr = {2'b11, 2'b01, 2'b10, p, r};
      int bad_pre = 0, bad_hdr = 0, bad_rel = 0;
      for (int i = 0; i < PRE; i++)
         if (out_bits[i] !== 1'b1 || oe_bits[i] !== 1'b1) bad_pre++;
      for (int i = 0; i < 16; i++)
         if (out_bits[PRE+i] !== hdr[15-i] || oe_bits[PRE+i] !== 1'b1) bad_hdr++;
      for (int i = 0; i < 19; i++)
         if (oe_bits[PRE+16+i] !== 1'b0) bad_rel++;
      chk("R2 read preamble", bad_pre, 0);
      chk("R3 read header", bad_hdr, 0);
      chk("R4 released clocks", bad_rel, 0);
      chk("R4 rising edge total", edge_cnt, PRE + 35);
   endtask

   task automatic check_write_frame(input logic [4:0] p, input logic [4:0] r,
                                    input logic [15:0] d);
      logic [31:0] frm = {2'b01, 2'b01, p, r, 2'b10, d};
      int bad_pre = 0, bad_frm = 0, bad_rel = 0;
      for (int i = 0; i < PRE; i++)
         if (out_bits[i] !== 1'b1 || oe_bits[i] !== 1'b1) bad_pre++;
      for (int i = 0; i < 32; i++)
         if (out_bits[PRE+i] !== frm[31-i] || oe_bits[PRE+i] !== 1'b1) bad_frm++;
      for (int i = 0; i < 2; i++)
         if (oe_bits[PRE+32+i] !== 1'b0) bad_rel++;
      chk("R2 write preamble", bad_pre, 0);
      chk("R5 write frame", bad_frm, 0);
      chk("R6 trailing released", bad_rel, 0);
      chk("R6 rising edge total", edge_cnt, PRE + 34);
   endtask

   task automatic t_reset();
      chk("R1 busy", {31'd0, busy}, 0);
      chk("R1 done", {31'd0, done}, 0);
      chk("R1 mdc", {31'd0, mdc}, 0);
      chk("R1 oe", {31'd0, mdio_oe}, 0);
   endtask

   task automatic t_serial_read(input logic [4:0] p, input logic [4:0] r,
                                input logic [15:0] d);
      rd_pat = {2'b10, d, 1'b1};
      edge_cnt = 0;
      issue(1'b0, {1'b0, p}, r, 16'h0);
      chk("R9 busy after accept", {31'd0, busy}, 1);
      wait_done();
      chk("R9 busy low in done cycle", {31'd0, busy}, 0);
      chk("R4 read data", rdata, d);
      check_read_frame(p, r);
      chk("R7 mdc period", 32'(rise_t[1] - rise_t[0]), 32'(2 * DIVH * TCLK));
      @(negedge clk);
      chk("R9 done one cycle", {31'd0, done}, 0);
      chk("R4 rdata held", rdata, d);
   endtask

   task automatic t_serial_write(input logic [4:0] p, input logic [4:0] r,
                                 input logic [15:0] d);
      edge_cnt = 0;
      issue(1'b1, {1'b0, p}, r, d);
      wait_done();
      check_write_frame(p, r, d);
   endtask

   task automatic t_busy_ignore();
      edge_cnt = 0;
      issue(1'b1, 6'd3, 5'd4, 16'h1234);
      repeat (10) @(negedge clk);
      issue(1'b1, 6'd32, 5'd4, 16'hBEEF);
      chk("R9 request during busy no done", {31'd0, done}, 0);
      chk("R9 still busy", {31'd0, busy}, 1);
      wait_done();
      check_write_frame(5'd3, 5'd4, 16'h1234);
      @(negedge clk);
      issue(1'b0, 6'd32, 5'd4, 16'h0);
      chk("R9 ignored write left reg 4", rdata, 16'h01E1);
   endtask

   task automatic t_back_to_back();
      rd_pat = {2'b10, 16'hA5C3, 1'b1};
      edge_cnt = 0;
      issue(1'b0, 6'd1, 5'd2, 16'h0);
      wait_done();
      chk("R4 b2b read data", rdata, 16'hA5C3);
      // present the next request in the done cycle
      edge_cnt = 0;
      issue(1'b1, 6'd30, 5'd17, 16'h5A0F);
      chk("R9 accepted in done cycle", {31'd0, busy}, 1);
      wait_done();
      check_write_frame(5'd30, 5'd17, 16'h5A0F);
   endtask

   task automatic t_local();
      edge_cnt = 0;
      issue(1'b0, 6'd32, 5'd1, 16'h0);
      chk("R10 local done next cycle", {31'd0, done}, 1);
      chk("R10 local not busy", {31'd0, busy}, 0);
      chk("R10 status reset value", rdata, 16'h7809);
      issue(1'b0, 6'd40, 5'd0, 16'h0);
      chk("R10 control reset value", rdata, 16'h1000);
      issue(1'b1, 6'd33, 5'd5, 16'hC0DE);
      chk("R10 local write done", {31'd0, done}, 1);
      issue(1'b1, 6'd63, 5'd6, 16'h0042);
      issue(1'b0, 6'd32, 5'd5, 16'h0);
      chk("R10 lpa readback", rdata, 16'hC0DE);
      issue(1'b0, 6'd32, 5'd6, 16'h0);
      chk("R10 expansion readback", rdata, 16'h0042);
      chk("R10 no mdc edges", edge_cnt, 0);
   endtask

   task automatic t_unmapped();
      issue(1'b1, 6'd32, 5'd2, 16'hFFFF);
      issue(1'b0, 6'd32, 5'd2, 16'h0);
      chk("R11 unmapped reg 2 reads zero", rdata, 16'h0000);
      issue(1'b1, 6'd32, 5'd7, 16'h1111);
      issue(1'b0, 6'd32, 5'd7, 16'h0);
      chk("R11 unmapped reg 7 reads zero", rdata, 16'h0000);
      issue(1'b0, 6'd32, 5'd4, 16'h0);
      chk("R11 neighbour reg 4 untouched", rdata, 16'h01E1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_serial_read(5'h0B, 5'h02, 16'h8E31);
      t_serial_read(5'h1F, 5'h1F, 16'h0001);
      t_serial_write(5'h15, 5'h0A, 16'hF00D);
      t_busy_ignore();
      t_back_to_back();
      t_local();
      t_unmapped();
      chk("R8 no change in high phase", hi_viol, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule